// File: doc/BRIEF.md
# Modem Control Handshake Sequencer

This block plays the data circuit device in a point-to-point asynchronous link and orders the control circuits it exchanges with a data terminal. A power-good input must stay high for a settling period before the device reports itself ready. A request to send from the terminal is accepted only while the device is ready. Clear to send answers it after a turnaround delay, and only then is the serial transmit path opened. Changes on the receive line raise carrier detect, which drops again once the line has been quiet for a timeout.

In full-duplex mode both directions run at once. In half-duplex mode an accepted request to send blocks the receive path until the request is withdrawn. All control circuits are single-bit on/off levels, where 1 means on. The idle (mark) level of both serial data lines is 1.

Top module: `modem_handshake_ctrl`

## Requirements
- R1: While reset is applied and for the cycles after it, dce_rdy, cts, dcd and rx_blocked are 0, and tx_line and rx_data are 1.
- R2: dce_rdy rises on the READY_CYC-th consecutive rising edge at which pwr_ok is sampled 1. It falls on the first edge at which pwr_ok is sampled 0.
- R3: cts rises on the (TURN_CYC+1)-th consecutive rising edge at which rts and dce_rdy are both sampled 1.
- R4: On the edge at which rts is sampled 0, cts falls.
- R5: An rts sampled while dce_rdy is 0 is ignored, so cts stays 0. An edge that samples dce_rdy as 0 clears cts.
- R6: tx_line follows tx_in while cts is 1 and is held at 1 otherwise.
- R7: dcd rises on the first edge at which rx_line differs from its value at the previous edge.
- R8: dcd falls on the IDLE_CYC-th consecutive edge without a change on rx_line.
- R9: rx_data is rx_line delayed by one edge while dcd is 1 and reception is not blocked. Otherwise it is 1.
- R10: With half_duplex at 1, rx_blocked is 1 and rx_data is 1 from the edge that accepts rts until the edge that samples rts as 0. With half_duplex at 0, rx_blocked stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Device-side power and line readiness |
| half_duplex | input | 1 | 1 selects half-duplex operation |
| rts | input | 1 | Request to send from the terminal |
| tx_in | input | 1 | Serial transmit data from the terminal |
| rx_line | input | 1 | Serial data from the line |
| dce_rdy | output | 1 | Device ready indication |
| cts | output | 1 | Clear to send |
| tx_line | output | 1 | Gated serial data toward the line |
| dcd | output | 1 | Carrier (received line signal) detect |
| rx_data | output | 1 | Gated serial data toward the terminal |
| rx_blocked | output | 1 | Receive path inhibited by half-duplex transmit |

## Verification
A wrong sequencer state appears at the ports within one edge. A handshake stuck in turnaround keeps cts and tx_line quiet past the expected edge. A stuck clear state keeps cts high after rts falls. A wrong idle counter shifts the dcd fall edge away from IDLE_CYC, and this is caught at the exact edge. A lost half-duplex block lets line data through rx_data while rts is held.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_TURN  = 2'd1,
    HS_CLEAR = 2'd2
  } hs_state_t;

  localparam logic MARK = 1'b1;
endpackage

// File: rtl/mdm_ready_gen.sv
module mdm_ready_gen #(
  parameter int READY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  output logic dce_rdy
);
  localparam int CW = $clog2(READY_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;
  logic          cnt_en;

  assign cnt_en = pwr_ok & ~rdy_q;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!pwr_ok) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == CW'(READY_CYC - 1)) begin
        rdy_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign dce_rdy = rdy_q;
endmodule

// File: rtl/mdm_rts_fsm.sv
module mdm_rts_fsm
  import mdm_pkg::*;
#(
  parameter int TURN_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dce_rdy,
  input  logic rts,
  output logic cts,
  output logic busy
);
  localparam int TW = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;

  hs_state_t     st_q, st_d;
  logic [TW-1:0] tc_q, tc_d;
  logic          go;

  assign go = rts & dce_rdy;

  always_comb begin
    st_d = st_q;
    tc_d = tc_q;
    unique case (st_q)
      HS_IDLE: begin
        tc_d = '0;
        if (go) st_d = HS_TURN;
      end
      HS_TURN: begin
        if (!go) begin
          st_d = HS_IDLE;
          tc_d = '0;
        end else if (tc_q == TW'(TURN_CYC - 1)) begin
          st_d = HS_CLEAR;
          tc_d = '0;
        end else begin
          tc_d = tc_q + TW'(1);
        end
      end
      HS_CLEAR: begin
        if (!go) st_d = HS_IDLE;
      end
      default: begin
        st_d = HS_IDLE;
        tc_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= HS_IDLE;
      tc_q <= '0;
    end else begin
      st_q <= st_d;
      tc_q <= tc_d;
    end
  end

  assign cts  = (st_q == HS_CLEAR);
  assign busy = (st_q != HS_IDLE);
endmodule

// File: rtl/mdm_carrier_det.sv
module mdm_carrier_det
  import mdm_pkg::*;
#(
  parameter int IDLE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic rx_samp,
  output logic dcd
);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic          line_q;
  logic          dcd_q, dcd_d;
  logic [IW-1:0] ic_q, ic_d;
  logic          act;
  logic          ic_en;

  assign act   = rx_line ^ line_q;
  assign ic_en = dcd_q & ~act;

  always_comb begin
    dcd_d = dcd_q;
    ic_d  = ic_q;
    if (act) begin
      dcd_d = 1'b1;
      ic_d  = '0;
    end else if (ic_en) begin
      if (ic_q == IW'(IDLE_CYC - 1)) begin
        dcd_d = 1'b0;
        ic_d  = '0;
      end else begin
        ic_d = ic_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= MARK;
      dcd_q  <= 1'b0;
      ic_q   <= '0;
    end else begin
      line_q <= rx_line;
      dcd_q  <= dcd_d;
      ic_q   <= ic_d;
    end
  end

  assign rx_samp = line_q;
  assign dcd     = dcd_q;
endmodule

// File: rtl/mdm_line_gate.sv
module mdm_line_gate
  import mdm_pkg::*;
(
  input  logic half_duplex,
  input  logic busy,
  input  logic cts,
  input  logic dcd,
  input  logic tx_in,
  input  logic rx_samp,
  output logic tx_line,
  output logic rx_data,
  output logic rx_blocked
);
  always_comb begin
    rx_blocked = half_duplex & busy;
    tx_line    = cts ? tx_in : MARK;
    rx_data    = (dcd & ~rx_blocked) ? rx_samp : MARK;
  end
endmodule

// File: rtl/modem_handshake_ctrl.sv
module modem_handshake_ctrl #(
  parameter int READY_CYC = 4,
  parameter int TURN_CYC  = 6,
  parameter int IDLE_CYC  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic half_duplex,
  input  logic rts,
  input  logic tx_in,
  input  logic rx_line,
  output logic dce_rdy,
  output logic cts,
  output logic tx_line,
  output logic dcd,
  output logic rx_data,
  output logic rx_blocked
);
  logic rst_s1, rst_s2;
  logic busy;
  logic rx_samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  mdm_ready_gen #(.READY_CYC(READY_CYC)) u_ready (
    .clk(clk), .rst_n(rst_s2), .pwr_ok(pwr_ok), .dce_rdy(dce_rdy)
  );

  mdm_rts_fsm #(.TURN_CYC(TURN_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_s2), .dce_rdy(dce_rdy), .rts(rts),
    .cts(cts), .busy(busy)
  );

  mdm_carrier_det #(.IDLE_CYC(IDLE_CYC)) u_car (
    .clk(clk), .rst_n(rst_s2), .rx_line(rx_line),
    .rx_samp(rx_samp), .dcd(dcd)
  );

  mdm_line_gate u_gate (
    .half_duplex(half_duplex), .busy(busy), .cts(cts), .dcd(dcd),
    .tx_in(tx_in), .rx_samp(rx_samp), .tx_line(tx_line),
    .rx_data(rx_data), .rx_blocked(rx_blocked)
  );
endmodule

// File: rtl/mdm_hs_checker.sv
module mdm_hs_checker (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok,
  input logic half_duplex,
  input logic rts,
  input logic tx_in,
  input logic rx_line,
  input logic dce_rdy,
  input logic cts,
  input logic tx_line,
  input logic dcd,
  input logic rx_data,
  input logic rx_blocked
);
  assert_rdy_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !dce_rdy);

  assert_cts_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts) |-> ($past(rts) && $past(dce_rdy)));

  assert_cts_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rts |=> !cts);

  assert_cts_needs_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dce_rdy |=> !cts);

  assert_tx_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cts |-> tx_line);

  assert_dcd_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_line != $past(rx_line)) |=> dcd);

  assert_dcd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dcd) |-> ($past(rx_line) == $past(rx_line, 2)));

  assert_rx_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dcd |-> rx_data);

  assert_block_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_blocked |-> (half_duplex && rx_data));

  assert_block_cts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (half_duplex && cts) |-> rx_blocked);
endmodule

bind modem_handshake_ctrl mdm_hs_checker u_hs_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .half_duplex(half_duplex),
  .rts(rts), .tx_in(tx_in), .rx_line(rx_line), .dce_rdy(dce_rdy),
  .cts(cts), .tx_line(tx_line), .dcd(dcd), .rx_data(rx_data),
  .rx_blocked(rx_blocked)
);

// File: tb/modem_handshake_ctrl_bench.sv
module modem_handshake_ctrl_bench;
  localparam int READY_CYC = 4;
  localparam int TURN_CYC  = 6;
  localparam int IDLE_CYC  = 20;

  logic clk, rst_n, pwr_ok, half_duplex, rts, tx_in, rx_line;
  logic dce_rdy, cts, tx_line, dcd, rx_data, rx_blocked;

  int n_chk = 0;
  int n_fail = 0;

  modem_handshake_ctrl #(.READY_CYC(READY_CYC), .TURN_CYC(TURN_CYC),
                         .IDLE_CYC(IDLE_CYC)) u_modem_handshake_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .half_duplex(half_duplex),
    .rts(rts), .tx_in(tx_in), .rx_line(rx_line), .dce_rdy(dce_rdy),
    .cts(cts), .tx_line(tx_line), .dcd(dcd), .rx_data(rx_data),
    .rx_blocked(rx_blocked)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pwr_ok = 1'b0; half_duplex = 1'b0; rts = 1'b0;
    tx_in = 1'b0; rx_line = 1'b1;
    tick(3);
    check("R1 dce_rdy in reset", dce_rdy, 1'b0);
    check("R1 cts in reset", cts, 1'b0);
    check("R1 tx_line in reset", tx_line, 1'b1);
    rst_n = 1'b1;
    tick(4);
    check("R1 dcd after reset", dcd, 1'b0);
    check("R1 rx_data after reset", rx_data, 1'b1);
    check("R1 rx_blocked after reset", rx_blocked, 1'b0);
  endtask

  task automatic t_ready;
    pwr_ok = 1'b1;
    tick(READY_CYC - 1);
    check("R2 dce_rdy before settle", dce_rdy, 1'b0);
    tick(1);
    check("R2 dce_rdy at settle", dce_rdy, 1'b1);
  endtask

  task automatic t_handshake;
    tx_in = 1'b0;
    rts = 1'b1;
    tick(TURN_CYC);
    check("R3 cts before turnaround", cts, 1'b0);
    check("R6 tx_line gated before cts", tx_line, 1'b1);
    tick(1);
    check("R3 cts after turnaround", cts, 1'b1);
    check("R6 tx_line follows 0", tx_line, 1'b0);
    tx_in = 1'b1; #1;
    check("R6 tx_line follows 1", tx_line, 1'b1);
    tx_in = 1'b0;
    tick(2);
    check("R3 cts held", cts, 1'b1);
    rts = 1'b0;
    tick(1);
    check("R4 cts falls after rts drop", cts, 1'b0);
    check("R6 tx_line mark after drop", tx_line, 1'b1);
  endtask

  task automatic t_not_ready;
    pwr_ok = 1'b0;
    tick(1);
    check("R2 dce_rdy falls", dce_rdy, 1'b0);
    rts = 1'b1;
    tick(TURN_CYC + 3);
    check("R5 rts ignored while not ready", cts, 1'b0);
    pwr_ok = 1'b1;
    tick(READY_CYC);
    check("R2 dce_rdy back", dce_rdy, 1'b1);
    tick(TURN_CYC);
    check("R3 cts not early after ready", cts, 1'b0);
    tick(1);
    check("R3 cts after ready and turnaround", cts, 1'b1);
    pwr_ok = 1'b0;
    tick(2);
    check("R5 cts cleared by ready loss", cts, 1'b0);
    rts = 1'b0;
    pwr_ok = 1'b1;
    tick(READY_CYC);
    check("R2 dce_rdy restored", dce_rdy, 1'b1);
  endtask

  task automatic t_carrier;
    rx_line = 1'b1;
    tick(2);
    check("R7 dcd idle line", dcd, 1'b0);
    rx_line = 1'b0;
    tick(1);
    check("R7 dcd on transition", dcd, 1'b1);
    check("R9 rx_data bit 0", rx_data, 1'b0);
    rx_line = 1'b1;
    tick(1);
    check("R9 rx_data bit 1", rx_data, 1'b1);
    rx_line = 1'b0;
    tick(1);
    check("R9 rx_data bit 0 again", rx_data, 1'b0);
    tick(IDLE_CYC - 1);
    check("R8 dcd held before timeout", dcd, 1'b1);
    tick(1);
    check("R8 dcd falls at timeout", dcd, 1'b0);
    check("R9 rx_data mark without carrier", rx_data, 1'b1);
  endtask

  task automatic t_halfdup;
    half_duplex = 1'b1;
    rx_line = 1'b1; tick(1);
    rx_line = 1'b0; tick(1);
    check("R7 dcd re-raised", dcd, 1'b1);
    check("R9 rx_data passes 0", rx_data, 1'b0);
    rts = 1'b1;
    tick(1);
    check("R10 rx_blocked on rts", rx_blocked, 1'b1);
    check("R10 rx_data mark while blocked", rx_data, 1'b1);
    tick(TURN_CYC);
    check("R10 still blocked with cts", rx_blocked, 1'b1);
    rts = 1'b0;
    tick(1);
    check("R10 block lifted", rx_blocked, 1'b0);
    check("R10 rx_data passes after lift", rx_data, 1'b0);
  endtask

  task automatic t_fulldup;
    half_duplex = 1'b0;
    rx_line = 1'b1; tick(1);
    rx_line = 1'b0; tick(1);
    rts = 1'b1;
    tick(TURN_CYC + 1);
    check("R10 full duplex cts", cts, 1'b1);
    check("R10 full duplex not blocked", rx_blocked, 1'b0);
    check("R9 full duplex rx_data passes", rx_data, 1'b0);
    rts = 1'b0;
    tick(1);
  endtask

  initial begin
    t_reset();
    t_ready();
    t_handshake();
    t_not_ready();
    t_carrier();
    t_halfdup();
    t_fulldup();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (R1..R10 run incomplete) actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule